// File: doc/BRIEF.md
# EDO DRAM Single-Word Controller

This block drives a 32-bit EDO DRAM array that takes its addresses multiplexed over twelve pins. On the user side it has a synchronous request port with a valid/ready handshake. A request carries a word address, a write flag, four byte enables and write data. Read data comes back later as a one-cycle response pulse. On the memory side it drives one active-low row strobe, four active-low column strobes (one per byte lane), a shared active-low write strobe, the multiplexed address and a split data bus.

After reset the controller waits out the power-up pause. It then runs a fixed number of CAS-before-RAS refreshes, and only after that does it accept requests. From then on a free-running interval timer raises refresh requests. A pending refresh wins over any user request that has not yet started. Each user access is one RAS cycle with one word. Writes use early-write timing, so the memory never drives the data pins. All strobe placements are parameter counts of clock cycles, derived from nanosecond parameters and a clock-period parameter, and always rounded up.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and just after it, rasN, all four casN and weN are high, dqOe is low and reqReady is low.
- R2: For word address A[21:0], the address bus carries A[21:10] while the row strobe falls. It carries {2'b00, A[9:0]} while the column strobes fall.
- R3: reqReady stays low until at least ceil(INIT_NS/CLK_NS) cycles after reset and until INIT_REFS (default 8) refresh cycles have been issued.
- R4: For a write, casN[i] falls exactly when byte enable i is set, and lane i is data bits [8i+7:8i]. For a read, all four casN fall.
- R5: A refresh is CAS-before-RAS: all casN are low for at least one cycle before rasN falls. weN is high from at least one cycle before rasN falls until rasN rises.
- R6: A write is an early write: weN is low at least one cycle before the column strobes fall. Write data is driven with dqOe high while they fall. dqOe is never high while weN is high.
- R7: A read returns the word on dqIn with exactly one rspValid pulse. At least ceil(T_RAC_NS/CLK_NS) cycles pass between the row-strobe fall and the sampling edge. Successive row-strobe falls are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R8: After initialisation, one refresh is issued for every ceil(REF_NS/CLK_NS) cycles of the free-running interval timer.
- R9: reqReady is low while the row strobe is low. A request raised during a refresh is held and completes after the refresh ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqAddr | input | 22 | Word address, row in upper 12 bits |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqBe | input | 4 | Byte enables for writes |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle read-data pulse |
| rspData | output | 32 | Read data |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 4 | Per-lane column strobes, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramAddr | output | 12 | Multiplexed address |
| dramDqOut | output | 32 | Data driven to memory |
| dramDqOe | output | 1 | Output enable for dramDqOut |
| dramDqIn | input | 32 | Data returned from memory |

## Verification
The assertions assume a synchronous reset, held low for several cycles from time zero, and request fields that stay stable from the cycle reqValid rises until the handshake edge. The bench drives every input on the falling clock edge and holds each request until reqReady has been seen high. It also models the memory itself, returning data on dqIn only while a column strobe is low with weN high. This keeps the read-sampling window inside the assumed behaviour.

// File: rtl/edoPkg.sv
package edoPkg;

  typedef struct packed {
    logic latch;      // capture request fields
    logic selCol;     // address bus shows column
    logic driveData;  // data bus enabled
    logic capture;    // sample read data on this edge
  } dpStrobeT;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_REFCAS, ST_REFRAS, ST_PRECH, ST_ROW, ST_COL
  } stateT;

  function automatic int ceilCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edoCtrl.sv
module edoCtrl
  import edoPkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int INIT_NS   = 200000,
  parameter int REF_NS    = 15600,
  parameter int INIT_REFS = 8,
  parameter int T_CSR_NS  = 5,
  parameter int T_CHR_NS  = 10,
  parameter int T_RAS_NS  = 60,
  parameter int T_RCD_NS  = 20,
  parameter int T_CAC_NS  = 15,
  parameter int T_RAC_NS  = 60,
  parameter int T_RP_NS   = 45,
  parameter int LANES     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWe,
  input  logic [LANES-1:0] reqBe,
  output logic             rasN,
  output logic [LANES-1:0] casN,
  output logic             weN,
  output dpStrobeT         strobe
);

  localparam int INIT_CYC = ceilCyc(INIT_NS, CLK_NS);
  localparam int REF_CYC  = ceilCyc(REF_NS, CLK_NS);
  localparam int CSR_CYC  = maxOf(ceilCyc(T_CSR_NS, CLK_NS), 1);
  localparam int RRAS_CYC = maxOf(ceilCyc(T_RAS_NS, CLK_NS), ceilCyc(T_CHR_NS, CLK_NS));
  localparam int RCD_CYC  = maxOf(ceilCyc(T_RCD_NS, CLK_NS), 1);
  localparam int COL_CYC  = maxOf(ceilCyc(T_CAC_NS, CLK_NS), ceilCyc(T_RAC_NS, CLK_NS) - RCD_CYC);
  localparam int RP_CYC   = maxOf(ceilCyc(T_RP_NS, CLK_NS), 1);
  localparam int CNT_W    = $clog2(INIT_CYC + 1);
  localparam int TMR_W    = $clog2(REF_CYC + 1);
  localparam int IREF_W   = $clog2(INIT_REFS + 1);

  stateT                 state;
  logic [CNT_W-1:0]      cnt;
  logic [TMR_W-1:0]      refTimer;
  logic                  refPending;
  logic [IREF_W-1:0]     initRefs;
  logic                  initDone;
  logic                  isWrite;
  logic [LANES-1:0]      beQ;
  logic                  cntZero;
  logic                  refStart;
  logic                  accept;

  assign initDone = (initRefs == IREF_W'(INIT_REFS));
  assign cntZero  = (cnt == '0);
  assign refStart = (state == ST_IDLE) && (!initDone || refPending);
  assign reqReady = (state == ST_IDLE) && initDone && !refPending;
  assign accept   = reqReady && reqValid;

  // refresh interval timer, free running from reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      if (refTimer == TMR_W'(REF_CYC - 1)) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
        if (refStart) refPending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_INIT;
      cnt      <= CNT_W'(INIT_CYC - 1);
      initRefs <= '0;
      isWrite  <= 1'b0;
      beQ      <= '0;
    end else begin
      if (!cntZero) cnt <= cnt - 1'b1;
      unique case (state)
        ST_INIT: if (cntZero) state <= ST_IDLE;
        ST_IDLE: begin
          if (refStart) begin
            state <= ST_REFCAS;
            cnt   <= CNT_W'(CSR_CYC - 1);
            if (!initDone) initRefs <= initRefs + 1'b1;
          end else if (accept) begin
            state   <= ST_ROW;
            cnt     <= CNT_W'(RCD_CYC - 1);
            isWrite <= reqWe;
            beQ     <= reqBe;
          end
        end
        ST_REFCAS: if (cntZero) begin state <= ST_REFRAS; cnt <= CNT_W'(RRAS_CYC - 1); end
        ST_REFRAS: if (cntZero) begin state <= ST_PRECH;  cnt <= CNT_W'(RP_CYC - 1);   end
        ST_ROW:    if (cntZero) begin state <= ST_COL;    cnt <= CNT_W'(COL_CYC - 1);  end
        ST_COL:    if (cntZero) begin state <= ST_PRECH;  cnt <= CNT_W'(RP_CYC - 1);   end
        ST_PRECH:  if (cntZero) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rasN = !(state inside {ST_ROW, ST_COL, ST_REFRAS});
    weN  = !(isWrite && (state inside {ST_ROW, ST_COL}));
    if (state inside {ST_REFCAS, ST_REFRAS}) casN = '0;
    else if (state == ST_COL)                casN = isWrite ? ~beQ : '0;
    else                                     casN = '1;
    strobe.latch     = accept;
    strobe.selCol    = (state == ST_COL);
    strobe.driveData = isWrite && (state inside {ST_ROW, ST_COL});
    strobe.capture   = (state == ST_COL) && cntZero && !isWrite;
  end

  // R3: no handshake before initialisation completes
  a_r3_ready_after_init: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> initDone);
  // R5: column strobes already low when a refresh row strobe falls, write strobe high
  a_r5_cbr_order: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && casN == '0 && $past(casN) == '0) |-> (weN && $past(weN)));
  // R6: write strobe low before column strobes fall
  a_r6_early_write: assert property (@(posedge clk) disable iff (!rstN)
    (casN != '1 && $past(casN) == '1 && !weN) |-> $past(!weN));
  // R4: reads open all lanes
  a_r4_read_all_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && casN != '1 && weN) |-> casN == '0);
  // R9: no acceptance while a row is open
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !reqReady);

endmodule

// File: rtl/edoDatapath.sv
module edoDatapath
  import edoPkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobeT                 strobe,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic [ROW_W-1:0]         dramAddr,
  output logic [DATA_W-1:0]        dramDqOut,
  output logic                     dramDqOe,
  input  logic [DATA_W-1:0]        dramDqIn,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData
);

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      wdataQ   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.latch) begin
        rowQ   <= reqAddr[ROW_W+COL_W-1:COL_W];
        colQ   <= reqAddr[COL_W-1:0];
        wdataQ <= reqWdata;
      end
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= dramDqIn;
    end
  end

  generate
    if (ROW_W > COL_W) begin : g_padCol
      assign dramAddr = strobe.selCol ? {{(ROW_W-COL_W){1'b0}}, colQ} : rowQ;
    end else begin : g_fullCol
      assign dramAddr = strobe.selCol ? colQ[ROW_W-1:0] : rowQ;
    end
  endgenerate

  assign dramDqOut = wdataQ;
  assign dramDqOe  = strobe.driveData;

  // R7: read response lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edoPkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int INIT_NS   = 200000,
  parameter int REF_NS    = 15600,
  parameter int INIT_REFS = 8,
  parameter int T_RAC_NS  = 60,
  parameter int T_RP_NS   = 45,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic                   reqWe,
  input  logic [DATA_W/8-1:0]    reqBe,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  output logic                   dramRasN,
  output logic [DATA_W/8-1:0]    dramCasN,
  output logic                   dramWeN,
  output logic [ROW_W-1:0]       dramAddr,
  output logic [DATA_W-1:0]      dramDqOut,
  output logic                   dramDqOe,
  input  logic [DATA_W-1:0]      dramDqIn
);

  localparam int LANES = DATA_W / 8;

  dpStrobeT strobe;

  edoCtrl #(
    .CLK_NS(CLK_NS), .INIT_NS(INIT_NS), .REF_NS(REF_NS), .INIT_REFS(INIT_REFS),
    .T_RAC_NS(T_RAC_NS), .T_RP_NS(T_RP_NS), .LANES(LANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWe(reqWe), .reqBe(reqBe), .rasN(dramRasN), .casN(dramCasN),
    .weN(dramWeN), .strobe(strobe)
  );

  edoDatapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramAddr(dramAddr), .dramDqOut(dramDqOut), .dramDqOe(dramDqOe),
    .dramDqIn(dramDqIn), .rspValid(rspValid), .rspData(rspData)
  );

  // R6: the bus is driven only together with the write strobe
  a_r6_oe_write_only: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> !dramWeN);

endmodule

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 20000;
  localparam int REF_CYC    = 1560;
  localparam int RAC_CYC    = 6;
  localparam int RC_CYC     = 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [21:0] reqAddr = '0;
  logic        reqWe = 1'b0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rasN;
  logic [3:0]  casN;
  logic        weN;
  logic [11:0] addr;
  logic [31:0] dqOut;
  logic        dqOe;
  logic [31:0] dqIn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  edo_dram_ctrl i_edo_dram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWe(reqWe), .reqBe(reqBe), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .dramRasN(rasN), .dramCasN(casN),
    .dramWeN(weN), .dramAddr(addr), .dramDqOut(dqOut), .dramDqOe(dqOe),
    .dramDqIn(dqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model, sampled on falling clock edges
  logic [31:0] mem [256];
  logic [11:0] latRow = '0, latCol = '0;
  logic        prevRas = 1'b1, prevWe = 1'b1, inRef = 1'b0;
  logic [3:0]  prevCas = 4'hF, lastWrCas = 4'hF, lastRdCas = 4'hF;
  int refCnt = 0, cbrBad = 0, ewBad = 0, oeBad = 0, rcBad = 0;
  int lastRasFall = -1000;

  assign dqIn = (!rasN && casN != 4'hF && weN) ? mem[{latRow[3:0], latCol[3:0]}] : 32'h0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        if (casN != 4'hF) begin
          refCnt++;
          inRef = 1'b1;
          if (prevCas != 4'h0 || !weN || !prevWe) cbrBad++;
        end else begin
          latRow = addr;
        end
        if (cyc - lastRasFall < RC_CYC) rcBad++;
        lastRasFall = cyc;
      end
      if (rasN) inRef = 1'b0;
      if (inRef && !weN) cbrBad++;
      if (!rasN && !inRef && casN != 4'hF && prevCas == 4'hF) begin
        latCol = addr;
        if (!weN) begin
          lastWrCas = casN;
          if (prevWe || !dqOe) ewBad++;
          for (int i = 0; i < 4; i++)
            if (!casN[i]) mem[{latRow[3:0], addr[3:0]}][8*i +: 8] = dqOut[8*i +: 8];
        end else begin
          lastRdCas = casN;
        end
      end
      if (dqOe && weN) oeBad++;
    end
    prevRas = rasN;
    prevCas = casN;
    prevWe  = weN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [21:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWe = 1'b1; reqBe = be; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic doRead(input logic [21:0] a, output logic [31:0] d, output int lat);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWe = 1'b0; reqBe = 4'h0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 50) begin @(negedge clk); n++; end
    d = rspData;
    lat = cyc - lastRasFall;
    @(negedge clk);
    check(!rspValid, "R7 pulse", rspValid, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(rasN && casN == 4'hF && weN && !dqOe && !reqReady, "R1",
          {rasN, casN, weN, dqOe, reqReady}, 8'b1_1111_1_0_0);
    rstN = 1'b1;
    @(negedge clk);
    check(rasN && casN == 4'hF && weN && !dqOe && !reqReady, "R1 after",
          {rasN, casN, weN, dqOe, reqReady}, 8'b1_1111_1_0_0);
  endtask

  task automatic testInit();
    while (!reqReady) @(negedge clk);
    check(cyc >= INIT_CYC, "R3 pause", cyc, INIT_CYC);
    check(refCnt == 8, "R3 refreshes", refCnt, 8);
  endtask

  task automatic testWriteRead();
    logic [31:0] d; int lat;
    doWrite(22'h0C15, 4'hF, 32'h11223344);
    check(latRow == 12'h003 && latCol == 12'h015, "R2 mux", {latRow, latCol}, 24'h003015);
    check(lastWrCas == 4'h0, "R4 full write lanes", lastWrCas, 0);
    doWrite(22'h1015, 4'hF, 32'hCAFEF00D);
    doRead(22'h0C15, d, lat);
    check(d == 32'h11223344, "R7 data", d, 32'h11223344);
    check(lat >= RAC_CYC, "R7 access", lat, RAC_CYC);
    check(lastRdCas == 4'h0, "R4 read lanes", lastRdCas, 0);
    doRead(22'h1015, d, lat);
    check(d == 32'hCAFEF00D, "R2 row distinct", d, 32'hCAFEF00D);
  endtask

  task automatic testByteEnables();
    logic [31:0] d; int lat;
    doWrite(22'h0C15, 4'b0101, 32'hAABBCCDD);
    check(lastWrCas == 4'b1010, "R4 partial lanes", lastWrCas, 4'b1010);
    doRead(22'h0C15, d, lat);
    check(d == 32'h11BB33DD, "R4 merge", d, 32'h11BB33DD);
  endtask

  task automatic testPeriodic();
    int base;
    base = refCnt;
    repeat (3 * REF_CYC + 50) @(negedge clk);
    check(refCnt - base >= 3 && refCnt - base <= 4, "R8 rate", refCnt - base, 3);
  endtask

  task automatic testCollision();
    logic [31:0] d; int lat; int busy; int n;
    n = 0;
    while (!inRef && n < 2000) begin @(negedge clk); n++; end
    reqValid = 1'b1; reqAddr = 22'h0427; reqWe = 1'b1; reqBe = 4'hF; reqWdata = 32'h5A5AA5A5;
    busy = 0;
    while (inRef) begin
      if (reqReady) busy++;
      @(negedge clk);
    end
    check(busy == 0, "R9 ready in refresh", busy, 0);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (14) @(negedge clk);
    doRead(22'h0427, d, lat);
    check(d == 32'h5A5AA5A5, "R9 held request", d, 32'h5A5AA5A5);
  endtask

  task automatic testProtocol();
    check(cbrBad == 0, "R5 refresh order", cbrBad, 0);
    check(ewBad == 0, "R6 early write", ewBad, 0);
    check(oeBad == 0, "R6 oe in read", oeBad, 0);
    check(rcBad == 0, "R7 cycle time", rcBad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    testReset();
    testInit();
    testWriteRead();
    testByteEnables();
    testPeriodic();
    testCollision();
    testProtocol();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule